// File: doc/BRIEF.md
# Magnitude-Indexed Complex Gain Predistorter

This block sits in the transmit path ahead of a power amplifier. It corrects each baseband sample by multiplying it by a complex gain picked from a small coefficient table. An external magnitude stage supplies the size of each sample. The table index comes from that magnitude, so amplitude-dependent gain and phase errors can be cancelled. When a single-sample index is not enough, an optional weighted sum over the current and two previous magnitudes forms the index. This models the heating of the amplifier by recent signal history.

The table sits in a two-port memory. The datapath reads through one port. An adaptation engine outside the block rewrites coefficients through the other port while samples keep flowing. Each sample is held in a matching delay so that it meets its own coefficient at the multiplier. A valid flag travels with every sample, and the latency is fixed.

Top module: `dpd_predistorter`

## Requirements
- R1: A sample presented with `in_vld` high at rising edge k gives `out_vld` high for exactly the cycle after edge k+3. `out_vld` is low in every other cycle.
- R2: With `fir_en` low, the table index is `in_mag[17:12]`.
- R3: A table word holds the real coefficient in bits [31:16] and the imaginary coefficient in bits [15:0]. Both are signed Q1.14, so 0x40000000 is unity gain. The outputs are `out_i = I*re - Q*im` and `out_q = I*im + Q*re`, scaled down by 2^14.
- R4: Rounding adds 2^13 to each 2^14-scaled sum and then shifts right arithmetically. Halves therefore round toward plus infinity: 1.5 gives 2, -1.5 gives -1, and -0.5 gives 0.
- R5: Results above 131071 become 131071, and results below -131072 become -131072.
- R6: The table is read at the edge after a sample is captured. A word written at or before the capture edge is used by that sample. A write at the read edge to the same index leaves that sample with the old word, and later samples get the new word.
- R7: With `fir_en` high, the index is bits [17:12] of F = (192*m0 + 96*m1 + 64*m2) >> 8. Here m0 is the current magnitude, and m1 and m2 are the magnitudes of the two previous valid samples. The history advances only on valid samples, whatever the state of `fir_en`.
- R8: When F exceeds 262143, the index saturates to 63.
- R9: `out_i` and `out_q` keep their last values while `out_vld` is low.
- R10: During reset, `out_vld`, `out_i` and `out_q` are zero, and the magnitude history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fir_en | input | 1 | Selects the filtered-history index |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 18 | In-phase sample, signed |
| in_q | input | 18 | Quadrature sample, signed |
| in_mag | input | 18 | Sample magnitude, unsigned |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | 6 | Coefficient write index |
| wr_data | input | 32 | Coefficient word {re, im} |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 18 | Corrected in-phase output |
| out_q | output | 18 | Corrected quadrature output |

## Verification
A wrong index or a mis-aligned sample delay produces the wrong complex product on the very sample it affects, four edges after capture. The bench therefore loads a distinct coefficient at every index before comparing outputs. A corrupted magnitude history is invisible while the filter is off, and it shows up on the first filtered sample afterwards. A bad read-during-write order appears only on the single sample that collides with a write. A valid flag slipping by one cycle shows up at once as a latency mismatch.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int unsigned SMP_W  = 18;
  localparam int unsigned CF_W   = 16;
  localparam int unsigned CF_FRC = 14;
  localparam int unsigned IDX_W  = 6;

  typedef struct packed {
    logic signed [CF_W-1:0] re;
    logic signed [CF_W-1:0] im;
  } coef_t;
endpackage

// File: rtl/dpd_addr_gen.sv
module dpd_addr_gen #(
  parameter int unsigned MAG_W  = 18,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NTAPS  = 3,
  parameter int unsigned TAP_W  = 8,
  parameter int unsigned SHIFT  = 8,
  parameter logic [NTAPS*TAP_W-1:0] WEIGHTS = {8'd64, 8'd96, 8'd192}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fir_en,
  input  logic              in_vld,
  input  logic [MAG_W-1:0]  in_mag,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int unsigned ACC_W = MAG_W + TAP_W + $clog2(NTAPS + 1);
  localparam int unsigned TOP   = SHIFT + MAG_W;

  logic [MAG_W-1:0]  tap_mag [NTAPS];
  logic [MAG_W-1:0]  hist_q  [NTAPS];
  logic [MAG_W-1:0]  hist_n  [NTAPS];
  logic [ACC_W-1:0]  acc;
  logic              ovf;
  logic [ADDR_W-1:0] fir_addr;
  logic [ADDR_W-1:0] addr_n;

  assign tap_mag[0] = in_mag;
  assign hist_q[0]  = '0;
  assign hist_n[0]  = '0;

  // History shift register: advances on valid samples only.
  for (genvar k = 1; k < NTAPS; k++) begin : g_hist
    always_comb begin
      hist_n[k] = hist_q[k];
      if (in_vld) hist_n[k] = tap_mag[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[k] <= '0;
      else        hist_q[k] <= hist_n[k];
    end
    assign tap_mag[k] = hist_q[k];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + ACC_W'(WEIGHTS[k*TAP_W +: TAP_W]) * ACC_W'(tap_mag[k]);
    end
  end

  if (ACC_W > TOP) begin : g_ovf
    assign ovf = |acc[ACC_W-1:TOP];
  end else begin : g_noovf
    assign ovf = 1'b0;
  end

  assign fir_addr = ovf ? {ADDR_W{1'b1}} : acc[TOP-1 -: ADDR_W];

  always_comb begin
    addr_n = addr_q;
    if (in_vld) addr_n = fir_en ? fir_addr : in_mag[MAG_W-1 -: ADDR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_q   <= addr_n;
      addr_vld <= in_vld;
    end
  end
endmodule

// File: rtl/dpd_coef_ram.sv
module dpd_coef_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_n;

  // Storage array carries no reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // A read at the same edge as a write sees the pre-write word.
  always_comb begin
    rd_n = rd_data;
    if (rd_en) rd_n = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_n;
  end
endmodule

// File: rtl/dpd_iq_delay.sv
module dpd_iq_delay #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  logic [W-1:0] d_q [DEPTH];
  logic [W-1:0] d_n [DEPTH];
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] v_n;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb begin
        v_n[k] = in_vld;
        d_n[k] = in_vld ? in_data : d_q[k];
      end
    end else begin : g_body
      always_comb begin
        v_n[k] = v_q[k-1];
        d_n[k] = v_q[k-1] ? d_q[k-1] : d_q[k];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[k] <= '0;
        v_q[k] <= 1'b0;
      end else begin
        d_q[k] <= d_n[k];
        v_q[k] <= v_n[k];
      end
    end
  end

  assign out_vld  = v_q[DEPTH-1];
  assign out_data = d_q[DEPTH-1];
endmodule

// File: rtl/dpd_cmul.sv
module dpd_cmul #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC   = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] x_q,
  input  logic signed [COEF_W-1:0] c_re,
  input  logic signed [COEF_W-1:0] c_im,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] y_i,
  output logic signed [DATA_W-1:0] y_q
);
  localparam int unsigned PW = DATA_W + COEF_W;
  localparam int unsigned SW = PW + 1;
  localparam logic signed [SW-1:0] HALF =
    {{(SW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [SW-1:0] OMAX =
    {{(SW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] OMIN =
    {{(SW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] p_ir_q, p_qi_q, p_ii_q, p_qr_q;
  logic signed [PW-1:0] p_ir_n, p_qi_n, p_ii_n, p_qr_n;
  logic                 pv_q;
  logic signed [SW-1:0] s_re, s_im;
  logic signed [DATA_W-1:0] y_i_n, y_q_n;

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] r;
    r = (s + HALF) >>> FRAC;
    if (r > OMAX)      rnd_sat = OMAX[DATA_W-1:0];
    else if (r < OMIN) rnd_sat = OMIN[DATA_W-1:0];
    else               rnd_sat = r[DATA_W-1:0];
  endfunction

  // Stage A: four real products.
  always_comb begin
    p_ir_n = p_ir_q;
    p_qi_n = p_qi_q;
    p_ii_n = p_ii_q;
    p_qr_n = p_qr_q;
    if (in_vld) begin
      p_ir_n = x_i * c_re;
      p_qi_n = x_q * c_im;
      p_ii_n = x_i * c_im;
      p_qr_n = x_q * c_re;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_ir_q <= '0;
      p_qi_q <= '0;
      p_ii_q <= '0;
      p_qr_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      p_ir_q <= p_ir_n;
      p_qi_q <= p_qi_n;
      p_ii_q <= p_ii_n;
      p_qr_q <= p_qr_n;
      pv_q   <= in_vld;
    end
  end

  // Stage B: one subtract, one add, round, saturate.
  always_comb begin
    s_re  = $signed({p_ir_q[PW-1], p_ir_q}) - $signed({p_qi_q[PW-1], p_qi_q});
    s_im  = $signed({p_ii_q[PW-1], p_ii_q}) + $signed({p_qr_q[PW-1], p_qr_q});
    y_i_n = y_i;
    y_q_n = y_q;
    if (pv_q) begin
      y_i_n = rnd_sat(s_re);
      y_q_n = rnd_sat(s_im);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_i     <= '0;
      y_q     <= '0;
      out_vld <= 1'b0;
    end else begin
      y_i     <= y_i_n;
      y_q     <= y_q_n;
      out_vld <= pv_q;
    end
  end
endmodule

// File: rtl/dpd_predistorter.sv
module dpd_predistorter
  import dpd_pkg::*;
#(
  parameter int unsigned DATA_W  = SMP_W,
  parameter int unsigned MAG_W   = 18,
  parameter int unsigned ADDR_W  = IDX_W,
  parameter int unsigned COEF_W  = CF_W,
  parameter int unsigned FRAC    = CF_FRC,
  parameter int unsigned NTAPS   = 3,
  parameter int unsigned TAP_W   = 8,
  parameter int unsigned TAP_SH  = 8,
  parameter logic [NTAPS*TAP_W-1:0] WEIGHTS = {8'd64, 8'd96, 8'd192}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fir_en,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [MAG_W-1:0]         in_mag,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [2*COEF_W-1:0]      wr_data,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);
  localparam int unsigned WORD_W = 2 * COEF_W;
  localparam int unsigned IQ_W   = 2 * DATA_W;
  localparam int unsigned ALIGN  = 2;  // index register + table read

  logic              addr_vld;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] coef_word;
  logic              iq_vld;
  logic [IQ_W-1:0]   iq_dly;

  dpd_addr_gen #(
    .MAG_W(MAG_W), .ADDR_W(ADDR_W), .NTAPS(NTAPS),
    .TAP_W(TAP_W), .SHIFT(TAP_SH), .WEIGHTS(WEIGHTS)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .fir_en(fir_en), .in_vld(in_vld),
    .in_mag(in_mag), .addr_vld(addr_vld), .addr_q(addr_q)
  );

  dpd_coef_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .rd_en(addr_vld), .rd_addr(addr_q),
    .rd_data(coef_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  dpd_iq_delay #(.W(IQ_W), .DEPTH(ALIGN)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data({in_i, in_q}),
    .out_vld(iq_vld), .out_data(iq_dly)
  );

  dpd_cmul #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_vld(iq_vld),
    .x_i($signed(iq_dly[IQ_W-1 -: DATA_W])),
    .x_q($signed(iq_dly[DATA_W-1:0])),
    .c_re($signed(coef_word[WORD_W-1 -: COEF_W])),
    .c_im($signed(coef_word[COEF_W-1:0])),
    .out_vld(out_vld), .y_i(out_i), .y_q(out_q)
  );
endmodule

// File: rtl/dpd_predistorter_chk.sv
module dpd_predistorter_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned MAG_W  = 18,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fir_en,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_i,
  input logic [DATA_W-1:0] in_q,
  input logic [MAG_W-1:0]  in_mag,
  input logic [ADDR_W-1:0] addr_q,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q
);
  // R1: fixed four-edge valid latency
  a_r1_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld, 4));

  // R2: unfiltered index follows the magnitude top bits
  a_r2_plain_index: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !fir_en) |=> addr_q == $past(in_mag[MAG_W-1 -: ADDR_W]));

  // R3: a zero sample leaves as zero whatever the coefficient
  a_r3_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_i == '0 && in_q == '0) |-> ##4 (out_i == '0 && out_q == '0));

  // R9: outputs hold while no valid result
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind dpd_predistorter dpd_predistorter_chk #(
  .DATA_W(DATA_W), .MAG_W(MAG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fir_en(fir_en), .in_vld(in_vld),
  .in_i(in_i), .in_q(in_q), .in_mag(in_mag), .addr_q(addr_q),
  .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_dpd_predistorter.sv
module sim_dpd_predistorter;
  logic clk = 1'b0;
  logic rst_n;
  logic fir_en;
  logic in_vld;
  logic signed [17:0] in_i, in_q;
  logic [17:0] in_mag;
  logic wr_en;
  logic [5:0] wr_addr;
  logic [31:0] wr_data;
  logic out_vld;
  logic signed [17:0] out_i, out_q;

  always #2 clk = ~clk;

  dpd_predistorter u0 (
    .clk(clk), .rst_n(rst_n), .fir_en(fir_en), .in_vld(in_vld),
    .in_i(in_i), .in_q(in_q), .in_mag(in_mag), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_vld(out_vld),
    .out_i(out_i), .out_q(out_q)
  );

  typedef struct {
    longint cyc;
    int ei;
    int eq;
    string tag;
  } exp_t;

  exp_t   expq[$];
  logic [31:0] tbl [64];
  longint cyc = 0;
  int     checks = 0;
  int     fails = 0;
  longint h1 = 0, h2 = 0;
  string  cur_tag = "R3";
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rsat(longint p);
    longint r;
    r = (p + 8192) >>> 14;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    return int'(r);
  endfunction

  function automatic int idx_of(longint m);
    longint f;
    if (!fir_en) return int'(m >> 12);
    f = (192 * m + 96 * h1 + 64 * h2) >> 8;
    if (f > 262143) return 63;
    return int'(f >> 12);
  endfunction

  task automatic report(string tag, string what, longint act, longint expv);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
  endtask

  // One cycle of stimulus; called right after a falling edge.
  task automatic step(bit v, int i, int q, int m, bit we, int wa, logic [31:0] wd);
    exp_t e;
    longint cr, ci;
    int a;
    in_vld = v; in_i = 18'(i); in_q = 18'(q); in_mag = 18'(m);
    wr_en = we; wr_addr = 6'(wa); wr_data = wd;
    if (we) tbl[wa] = wd;
    if (v) begin
      a  = idx_of(m);
      cr = longint'($signed(tbl[a][31:16]));
      ci = longint'($signed(tbl[a][15:0]));
      e.cyc = cyc + 4;
      e.ei  = rsat(longint'(i) * cr - longint'(q) * ci);
      e.eq  = rsat(longint'(i) * ci + longint'(q) * cr);
      e.tag = cur_tag;
      expq.push_back(e);
      h2 = h1; h1 = m;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic drain();
    idle(6);
    checks++;
    if (expq.size() != 0) report(cur_tag, "missing outputs", expq.size(), 0);
    expq.delete();
  endtask

  // Output monitor: compares value and arrival cycle (R1).
  always @(negedge clk) begin
    if (rst_n && !done && out_vld) begin
      checks++;
      if (expq.size() == 0) report("R1", "unexpected out_vld", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        if (cyc != e.cyc) report("R1", "latency cycle", cyc, e.cyc);
        else if (out_i != e.ei) report(e.tag, "out_i", out_i, e.ei);
        else if (out_q != e.eq) report(e.tag, "out_q", out_q, e.eq);
      end
    end
  end

  task automatic t_reset();
    cur_tag = "R10";
    rst_n = 0; fir_en = 0; in_vld = 0; in_i = 0; in_q = 0; in_mag = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_i !== 18'sd0 || out_q !== 18'sd0)
      report("R10", "reset outputs", {out_vld, out_i, out_q}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_unity();
    cur_tag = "R3";
    for (int a = 0; a < 64; a++) step(0, 0, 0, 0, 1, a, 32'h4000_0000);
    step(1, 1000, -2000, 5000, 0, 0, 0);
    step(1, -131072, 131071, 262143, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, -7, 12345, 100000, 0, 0, 0);
    drain();
  endtask

  task automatic t_addr_select();
    cur_tag = "R2";
    for (int a = 0; a < 64; a++)
      step(0, 0, 0, 0, 1, a, {16'(16'h2000 + a * 128), 16'(a * 97 - 3000)});
    step(1, 40000, 30000, 0, 0, 0, 0);
    step(1, 40000, 30000, 4095, 0, 0, 0);
    step(1, 40000, 30000, 4096, 0, 0, 0);
    step(1, -50000, 70000, 21 * 4096 + 17, 0, 0, 0);
    step(1, 12000, -9000, 262143, 0, 0, 0);
    step(1, 12000, -9000, 32 * 4096, 0, 0, 0);
    drain();
  endtask

  task automatic t_round();
    cur_tag = "R4";
    step(0, 0, 0, 0, 1, 0, 32'h2000_0000);
    step(1, 3, 1, 0, 0, 0, 0);
    step(1, -3, -1, 0, 0, 0, 0);
    step(1, 5, -5, 0, 0, 0, 0);
    drain();
  endtask

  task automatic t_sat();
    cur_tag = "R5";
    step(0, 0, 0, 0, 1, 1, 32'h7FFF_0000);
    step(0, 0, 0, 0, 1, 2, 32'h8000_7FFF);
    step(1, 131071, -131072, 4096, 0, 0, 0);
    step(1, 131071, 131071, 8192, 0, 0, 0);
    step(1, -131072, 100, 8192, 0, 0, 0);
    drain();
  endtask

  task automatic t_collide();
    cur_tag = "R6";
    step(0, 0, 0, 0, 1, 9, 32'h4000_0000);
    step(1, 20000, 10000, 9 * 4096, 0, 0, 0);
    step(0, 0, 0, 0, 1, 9, 32'h1000_2000);
    step(1, 20000, 10000, 9 * 4096, 0, 0, 0);
    step(1, 20000, 10000, 9 * 4096, 1, 9, 32'h3000_E000);
    drain();
  endtask

  task automatic t_fir();
    cur_tag = "R7";
    for (int a = 0; a < 64; a++)
      step(0, 0, 0, 0, 1, a, {16'(16'h1000 + a * 200), 16'(a * 150)});
    fir_en = 1;
    step(1, 30000, -20000, 200000, 0, 0, 0);
    step(1, 30000, -20000, 10000, 0, 0, 0);
    step(0, 0, 0, 250000, 0, 0, 0);
    step(1, -15000, 25000, 120000, 0, 0, 0);
    step(1, 15000, 25000, 0, 0, 0, 0);
    fir_en = 0;
    step(1, 15000, 25000, 180000, 0, 0, 0);
    step(1, 15000, 25000, 60000, 0, 0, 0);
    fir_en = 1;
    step(1, 8000, -8000, 90000, 0, 0, 0);
    fir_en = 0;
    drain();
  endtask

  task automatic t_fir_sat();
    cur_tag = "R8";
    fir_en = 1;
    step(1, 30000, 1000, 262143, 0, 0, 0);
    step(1, 30000, 1000, 262143, 0, 0, 0);
    step(1, 30000, 1000, 262143, 0, 0, 0);
    step(1, 30000, 1000, 230000, 0, 0, 0);
    fir_en = 0;
    drain();
  endtask

  task automatic t_hold();
    logic signed [17:0] li, lq;
    cur_tag = "R9";
    step(1, 777, -555, 5 * 4096, 0, 0, 0);
    drain();
    li = out_i; lq = out_q;
    step(0, 99999, -99999, 262143, 1, 5, 32'h7FFF_7FFF);
    step(0, -1, 1, 1234, 0, 0, 0);
    idle(5);
    checks++;
    if (out_vld !== 1'b0 || out_i !== li || out_q !== lq)
      report("R9", "held outputs changed", {out_i, out_q}, {li, lq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unity();
    t_addr_select();
    t_round();
    t_sat();
    t_collide();
    t_fir();
    t_fir_sat();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule